// File: doc/BRIEF.md
# Operating-State Clock Source Selector

This block is the control side of a processor core clock selector. A 32-bit control register holds a one-hot operating-state field and one source-index field per state. The block decodes which state is active, pulls the matching source index out of the register and drives it to the clock switching logic as the effective source select. A halved copy of one PLL is reached through that PLL's index plus a cleared bypass bit, and the block then reports the halved source and raises a divide-by-two enable.

Software changes the source in two ways. It can write the control register directly over a single-cycle register bus. It can also post an index on a valid/ready request port, and the block then performs the read-modify-write itself. A swap between the direct and the halved PLL is refused while either of them is the active source. An accepted swap is done in two steps: the bypass bit is inverted, and after a settle interval the PLL index is written into the active field. Every register update starts a settle counter with a programmable length, and no further update is taken while it runs.

Top module: `cpu_clk_src_ctl`

## Requirements
- R1: After reset the control register reads 0x2000_0000 (run state only), src_sel_o is 0, half_en_o, err_o, fault_o and busy_o are 0, req_ready_o is 1 and the settle length reads SETTLE_RST (3).
- R2: State bits [31:28] are one-hot: bit 28 idle, bit 29 run. In idle the active field is bits [W-1:0]; in run it is bits [2W-1:W] (field LSB at W times the state number). src_sel_o shows the active field.
- R3: With DIV2_EN set, bypass bit 16 clear and the active field equal to PLLX_IDX (8), src_sel_o is DIV2_IDX (9) and half_en_o is 1; with bit 16 set, src_sel_o is PLLX_IDX and half_en_o is 0.
- R4: An accepted request for any index other than PLLX_IDX or DIV2_IDX writes that index into the active field only; all other register bits keep their value.
- R5: A request for PLLX_IDX or DIV2_IDX while src_sel_o is PLLX_IDX or DIV2_IDX leaves the register unchanged, starts no settle interval and sets err_o.
- R6: An accepted request for PLLX_IDX or DIV2_IDX first inverts bit 16 with the field unchanged; once that settle interval ends, the next cycle writes PLLX_IDX into the active field.
- R7: Each register update (accepted bus write to the control register or a request step) holds busy_o high for exactly the settle length in cycles, programmed at bus address 2; req_ready_o is low while busy_o is high or a two-step swap is pending, so a plain request is ready again L cycles after its handshake and a swap 2L+1 cycles after.
- R8: A bus write to the control register while busy_o is high or a swap is pending is ignored.
- R9: While the state field is neither exactly idle nor exactly run, src_sel_o and half_en_o are 0, fault_o is set the next cycle, and an accepted request leaves the register unchanged.
- R10: err_o (status bit 0) and fault_o (status bit 1) are sticky and clear by writing ones to bus address 1; a set condition in the same cycle wins over the clear.
- R11: bus_rdata_o shows the control register at address 0, {fault, err} in bits [1:0] at address 1 and the settle length at address 2, in the same cycle as the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register bus access strobe |
| bus_we_i | input | 1 | Write enable for the access |
| bus_addr_i | input | 2 | Word address: 0 control, 1 status, 2 settle length |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| req_valid_i | input | 1 | Source request valid |
| req_idx_i | input | W | Requested source index |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| src_sel_o | output | W | Effective source select |
| half_en_o | output | 1 | Divide-by-two path enable |
| busy_o | output | 1 | Settle interval running |
| err_o | output | 1 | Sticky refused-swap flag |
| fault_o | output | 1 | Sticky invalid-state flag |

## Verification
Register contents, src_sel_o and half_en_o change on the clock edge that takes a bus write or request step, so the bench reads them at the falling edge that follows. The sticky flags are registered one edge after the condition and are checked one full cycle later. busy_o and req_ready_o are counted at falling edges after the handshake: L cycles for a plain update and 2L+1 for a bypass swap, with the intermediate bypass-only value read back at the first falling edge after the handshake. Bus reads are sampled shortly after the address settles.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam int REG_W     = 32;
  localparam int STATE_LSB = 28;
  localparam int BYP_BIT   = 16;

  localparam logic [3:0] ST_IDLE_OH = 4'b0001;
  localparam logic [3:0] ST_RUN_OH  = 4'b0010;

  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_STAT   = 2'd1,
    A_SETTLE = 2'd2
  } reg_addr_e;

  typedef enum logic {
    SEQ_IDLE,
    SEQ_FIELD
  } seq_e;
endpackage

// File: rtl/sclk_decode.sv
module sclk_decode #(
  parameter int W        = 4,
  parameter int PLLX_IDX = 8,
  parameter int DIV2_IDX = 9,
  parameter bit DIV2_EN  = 1'b1
) (
  input  logic [2*W-1:0] fields_i,
  input  logic [3:0]     state_i,
  input  logic           bypass_i,
  output logic           state_ok_o,
  output logic           run_sel_o,
  output logic [W-1:0]   src_o,
  output logic           half_o
);
  import sclk_pkg::*;

  localparam int N_SEL = 2;
  localparam logic [W-1:0] PLLX_L = PLLX_IDX[W-1:0];
  localparam logic [W-1:0] DIV2_L = DIV2_IDX[W-1:0];

  logic [W-1:0] fld [N_SEL];
  logic [W-1:0] raw;

  for (genvar s = 0; s < N_SEL; s++) begin : g_fld
    assign fld[s] = fields_i[s*W +: W];
  end

  always_comb begin
    state_ok_o = (state_i == ST_IDLE_OH) || (state_i == ST_RUN_OH);
    run_sel_o  = (state_i == ST_RUN_OH);
    raw        = state_ok_o ? fld[run_sel_o] : '0;
    half_o     = DIV2_EN && state_ok_o && !bypass_i && (raw == PLLX_L);
    src_o      = half_o ? DIV2_L : raw;
  end
endmodule

// File: rtl/sclk_settle.sv
module sclk_settle #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= len_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/sclk_seq.sv
module sclk_seq #(
  parameter int W        = 4,
  parameter int PLLX_IDX = 8,
  parameter int DIV2_IDX = 9,
  parameter bit DIV2_EN  = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_valid_i,
  input  logic [W-1:0] req_idx_i,
  input  logic         busy_i,
  input  logic         bus_hold_i,
  input  logic         state_ok_i,
  input  logic [W-1:0] cur_src_i,
  output logic         ready_o,
  output logic         seq_idle_o,
  output logic         do_toggle_o,
  output logic         do_field_o,
  output logic [W-1:0] field_val_o,
  output logic         err_set_o
);
  import sclk_pkg::*;

  localparam logic [W-1:0] PLLX_L = PLLX_IDX[W-1:0];
  localparam logic [W-1:0] DIV2_L = DIV2_IDX[W-1:0];

  seq_e st_q, st_d;
  logic hs, pll_req, pll_cur;

  assign seq_idle_o = (st_q == SEQ_IDLE);
  assign ready_o    = seq_idle_o && !busy_i && !bus_hold_i;
  assign hs         = req_valid_i && ready_o;
  assign pll_req    = DIV2_EN && ((req_idx_i == PLLX_L) || (req_idx_i == DIV2_L));
  assign pll_cur    = (cur_src_i == PLLX_L) || (cur_src_i == DIV2_L);

  always_comb begin
    st_d        = st_q;
    do_toggle_o = 1'b0;
    do_field_o  = 1'b0;
    field_val_o = req_idx_i;
    err_set_o   = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (hs && state_ok_i) begin
          if (pll_req) begin
            if (pll_cur) begin
              err_set_o = 1'b1;
            end else begin
              do_toggle_o = 1'b1;
              st_d        = SEQ_FIELD;
            end
          end else begin
            do_field_o = 1'b1;
          end
        end
      end
      SEQ_FIELD: begin
        // second step once the bypass change has settled
        if (!busy_i) begin
          do_field_o  = 1'b1;
          field_val_o = PLLX_L;
          st_d        = SEQ_IDLE;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SEQ_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/cpu_clk_src_ctl.sv
module cpu_clk_src_ctl #(
  parameter int W          = 4,
  parameter int PLLX_IDX   = 8,
  parameter int DIV2_IDX   = 9,
  parameter bit DIV2_EN    = 1'b1,
  parameter int CNT_W      = 8,
  parameter int SETTLE_RST = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_sel_i,
  input  logic          bus_we_i,
  input  logic [1:0]    bus_addr_i,
  input  logic [31:0]   bus_wdata_i,
  output logic [31:0]   bus_rdata_o,
  input  logic          req_valid_i,
  input  logic [W-1:0]  req_idx_i,
  output logic          req_ready_o,
  output logic [W-1:0]  src_sel_o,
  output logic          half_en_o,
  output logic          busy_o,
  output logic          err_o,
  output logic          fault_o
);
  import sclk_pkg::*;

  localparam logic [REG_W-1:0] CTRL_RST = REG_W'(1) << (STATE_LSB + 1);
  localparam logic [REG_W-1:0] FMASK0   = {{(REG_W-W){1'b0}}, {W{1'b1}}};

  logic [REG_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0] settle_q;
  logic             err_q, fault_q;

  logic ctrl_wr, stat_wr, settle_wr, ctrl_acc;
  logic state_ok, run_sel, seq_idle;
  logic do_toggle, do_field, err_set;
  logic [W-1:0] field_val;
  logic [REG_W-1:0] fmask, fval;
  int unsigned off;

  assign ctrl_wr   = bus_sel_i && bus_we_i && (bus_addr_i == A_CTRL);
  assign stat_wr   = bus_sel_i && bus_we_i && (bus_addr_i == A_STAT);
  assign settle_wr = bus_sel_i && bus_we_i && (bus_addr_i == A_SETTLE);
  assign ctrl_acc  = ctrl_wr && seq_idle && !busy_o;

  sclk_decode #(
    .W(W), .PLLX_IDX(PLLX_IDX), .DIV2_IDX(DIV2_IDX), .DIV2_EN(DIV2_EN)
  ) u_dec (
    .fields_i   (ctrl_q[2*W-1:0]),
    .state_i    (ctrl_q[STATE_LSB +: 4]),
    .bypass_i   (ctrl_q[BYP_BIT]),
    .state_ok_o (state_ok),
    .run_sel_o  (run_sel),
    .src_o      (src_sel_o),
    .half_o     (half_en_o)
  );

  sclk_seq #(
    .W(W), .PLLX_IDX(PLLX_IDX), .DIV2_IDX(DIV2_IDX), .DIV2_EN(DIV2_EN)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_idx_i   (req_idx_i),
    .busy_i      (busy_o),
    .bus_hold_i  (ctrl_wr),
    .state_ok_i  (state_ok),
    .cur_src_i   (src_sel_o),
    .ready_o     (req_ready_o),
    .seq_idle_o  (seq_idle),
    .do_toggle_o (do_toggle),
    .do_field_o  (do_field),
    .field_val_o (field_val),
    .err_set_o   (err_set)
  );

  sclk_settle #(.CNT_W(CNT_W)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ctrl_acc || do_toggle || do_field),
    .len_i   (settle_q),
    .busy_o  (busy_o)
  );

  always_comb begin
    off    = run_sel ? W : 0;
    fmask  = FMASK0 << off;
    fval   = {{(REG_W-W){1'b0}}, field_val} << off;
    ctrl_d = ctrl_q;
    if (ctrl_acc)       ctrl_d = bus_wdata_i;
    else if (do_toggle) ctrl_d = ctrl_q ^ (REG_W'(1) << BYP_BIT);
    else if (do_field)  ctrl_d = (ctrl_q & ~fmask) | fval;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= CTRL_RST;
      settle_q <= CNT_W'(SETTLE_RST);
      err_q    <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (settle_wr) settle_q <= bus_wdata_i[CNT_W-1:0];
      // set beats write-one-to-clear
      err_q   <= err_set   || (err_q   && !(stat_wr && bus_wdata_i[0]));
      fault_q <= !state_ok || (fault_q && !(stat_wr && bus_wdata_i[1]));
    end
  end

  assign err_o   = err_q;
  assign fault_o = fault_q;

  always_comb begin
    unique case (bus_addr_i)
      A_CTRL:   bus_rdata_o = ctrl_q;
      A_STAT:   bus_rdata_o = {30'd0, fault_q, err_q};
      A_SETTLE: bus_rdata_o = {{(REG_W-CNT_W){1'b0}}, settle_q};
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sclk_chk.sv
module sclk_chk #(
  parameter int W        = 4,
  parameter int DIV2_IDX = 9
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         bus_sel_i,
  input logic         bus_we_i,
  input logic [1:0]   bus_addr_i,
  input logic [1:0]   wbits_i,
  input logic         req_valid_i,
  input logic         req_ready_o,
  input logic [W-1:0] src_sel_o,
  input logic         half_en_o,
  input logic         busy_o,
  input logic         err_o,
  input logic         fault_o,
  input logic [31:0]  ctrl_q
);
  logic bad_st, stat_wr, ctrl_wr;
  assign bad_st  = !((ctrl_q[31:28] == 4'b0001) || (ctrl_q[31:28] == 4'b0010));
  assign stat_wr = bus_sel_i && bus_we_i && (bus_addr_i == 2'd1);
  assign ctrl_wr = bus_sel_i && bus_we_i && (bus_addr_i == 2'd0);

  p_busy_blocks_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_ready_o);

  p_half_reports_div2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_en_o |-> (src_sel_o == DIV2_IDX[W-1:0]));

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !(stat_wr && wbits_i[0])) |=> err_o);

  p_fault_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !(stat_wr && wbits_i[1])) |=> fault_o);

  p_bad_state_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_st |=> fault_o);

  p_bad_state_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_st && req_valid_i && req_ready_o && !ctrl_wr) |=> $stable(ctrl_q));

  p_write_while_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && busy_o) |=> $stable(ctrl_q));
endmodule

bind cpu_clk_src_ctl sclk_chk #(.W(W), .DIV2_IDX(DIV2_IDX)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_sel_i   (bus_sel_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .wbits_i     (bus_wdata_i[1:0]),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .src_sel_o   (src_sel_o),
  .half_en_o   (half_en_o),
  .busy_o      (busy_o),
  .err_o       (err_o),
  .fault_o     (fault_o),
  .ctrl_q      (ctrl_q)
);

// File: tb/sim_cpu_clk_src_ctl.sv
module sim_cpu_clk_src_ctl;
  localparam int W = 4;
  localparam int PLLX = 8;
  localparam int DIV2 = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic req_valid = 1'b0;
  logic [W-1:0] req_idx = '0;
  logic req_ready, half_en, busy, err, fault;
  logic [W-1:0] src_sel;

  int n_chk = 0, n_err = 0;
  int settle = 3;
  logic [31:0] exp_ctrl;
  logic exp_err = 1'b0;

  always #10 clk = ~clk;

  cpu_clk_src_ctl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_sel_i(bus_sel), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .req_valid_i(req_valid), .req_idx_i(req_idx), .req_ready_o(req_ready),
    .src_sel_o(src_sel), .half_en_o(half_en), .busy_o(busy),
    .err_o(err), .fault_o(fault)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff_src(input logic [31:0] c);
    int f;
    if (c[31:28] == 4'b0001)      f = int'(c[3:0]);
    else if (c[31:28] == 4'b0010) f = int'((c >> W) & 32'hF);
    else return 0;
    if (!c[16] && f == PLLX) return DIV2;
    return f;
  endfunction

  function automatic bit eff_half(input logic [31:0] c);
    return (eff_src(c) == DIV2) && (c[31:28] inside {4'b0001, 4'b0010});
  endfunction

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata; bus_sel = 0;
  endtask

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic check_outputs(input string tag);
    logic [31:0] rd;
    bus_rd(2'd0, rd);
    chk({tag, " ctrl"}, rd, exp_ctrl);
    chk({tag, " src"}, src_sel, eff_src(exp_ctrl));
    chk({tag, " half"}, half_en, eff_half(exp_ctrl));
  endtask

  task automatic wr_ctrl(input logic [31:0] d);
    bus_wr(2'd0, d);
    exp_ctrl = d;
    wait_ready();
  endtask

  // request; model update and settle-time check
  task automatic do_req(input logic [W-1:0] idx, input string tag);
    int n, cur, sh;
    bit pll, bad, refuse;
    logic [31:0] mid;
    cur = eff_src(exp_ctrl);
    bad = !(exp_ctrl[31:28] inside {4'b0001, 4'b0010});
    pll = (idx == PLLX) || (idx == DIV2);
    refuse = bad || (pll && (cur == PLLX || cur == DIV2));
    sh = (exp_ctrl[31:28] == 4'b0010) ? W : 0;
    @(negedge clk); req_valid = 1; req_idx = idx;
    wait_ready();
    @(negedge clk); req_valid = 0;
    if (pll && !refuse) begin
      // R6: bypass first, field untouched
      #1 mid = bus_rdata;
      chk({tag, " R6 mid bypass"}, mid, exp_ctrl ^ 32'h0001_0000);
    end
    n = 0;
    while (!req_ready) begin @(negedge clk); n++; end
    if (refuse) begin
      chk({tag, " R5/R9 no settle"}, n, 0);
      if (!bad) exp_err = 1'b1;
    end else if (pll) begin
      exp_ctrl = exp_ctrl ^ 32'h0001_0000;
      exp_ctrl = (exp_ctrl & ~(32'hF << sh)) | (32'(PLLX) << sh);
      chk({tag, " R7 swap settle"}, n, 2 * settle + 1);
    end else begin
      exp_ctrl = (exp_ctrl & ~(32'hF << sh)) | (32'(idx) << sh);
      chk({tag, " R7 settle"}, n, settle);
    end
    check_outputs(tag);
    chk({tag, " R5 err"}, err, exp_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    exp_ctrl = 32'h2000_0000;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 src", src_sel, 0);
    chk("R1 half", half_en, 0);
    chk("R1 err", err, 0);
    chk("R1 fault", fault, 0);
    chk("R1 busy", busy, 0);
    chk("R1 ready", req_ready, 1);
    check_outputs("R1");
    bus_rd(2'd2, rd); chk("R1 R11 settle len", rd, 3);

    // R2/R4 sweep both valid states, all plain indices, both bypass values
    for (int st = 0; st < 2; st++) begin
      for (int byp = 0; byp < 2; byp++) begin
        wr_ctrl((32'h1000_0000 << st) | (32'(byp) << 16) | 32'h0000_A5C3);
        check_outputs("R2 write");
        for (int i = 0; i < 16; i++) begin
          if (i == PLLX || i == DIV2) continue;
          do_req(W'(i), st == 0 ? "R4 idle" : "R4 run");
        end
      end
    end

    // R3 substitution through direct writes
    wr_ctrl(32'h2000_0080); check_outputs("R3 run half");
    chk("R3 half_en", half_en, 1);
    wr_ctrl(32'h2001_0080); check_outputs("R3 run direct");
    wr_ctrl(32'h1000_0008); check_outputs("R3 idle half");

    // R5 refusal and R10 clear
    do_req(W'(PLLX), "R5 pll while div2");
    do_req(W'(DIV2), "R5 div2 while div2");
    bus_wr(2'd1, 32'h1); exp_err = 1'b0;
    @(negedge clk); chk("R10 err cleared", err, 0);

    // R6 swaps from a plain source
    do_req(W'(3), "R4 leave pll");
    do_req(W'(DIV2), "R6 toggle to direct");
    do_req(W'(PLLX), "R5 pll while pll");
    bus_wr(2'd1, 32'h1); exp_err = 1'b0;
    do_req(W'(2), "R4 leave pll2");
    do_req(W'(DIV2), "R6 toggle to half");
    chk("R6 half_en", half_en, 1);

    // R7 settle length programming
    bus_wr(2'd2, 32'd0); settle = 0;
    bus_rd(2'd2, rd); chk("R11 settle readback", rd, 0);
    do_req(W'(5), "R7 zero settle");
    do_req(W'(PLLX), "R7 zero settle swap");
    bus_wr(2'd1, 32'h1); exp_err = 1'b0;
    do_req(W'(6), "R7 zero settle leave");
    do_req(W'(PLLX), "R7 zero settle swap2");
    bus_wr(2'd2, 32'd5); settle = 5;
    do_req(W'(1), "R7 long settle");

    // R8 write during busy ignored
    bus_wr(2'd0, 32'h2000_0070);
    chk("R8 busy after write", busy, 1);
    bus_wr(2'd0, 32'h1000_0004);
    exp_ctrl = 32'h2000_0070;
    wait_ready();
    check_outputs("R8 ignored write");

    // R9 invalid states
    for (int s = 0; s < 3; s++) begin
      logic [31:0] v;
      v = (s == 0) ? 32'h4000_0011 : (s == 1) ? 32'h8000_0011 : 32'h3000_0011;
      wr_ctrl(v);
      chk("R9 fault set", fault, 1);
      chk("R9 src zero", src_sel, 0);
      do_req(W'(2), "R9 refused");
      bus_wr(2'd1, 32'h2);
      @(negedge clk); chk("R10 set wins over clear", fault, 1);
      bus_rd(2'd1, rd); chk("R11 status", rd, 32'h2);
    end
    wr_ctrl(32'h2000_0000);
    bus_wr(2'd1, 32'h3);
    @(negedge clk);
    chk("R10 fault cleared", fault, 0);
    check_outputs("R9 recovered");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule